// File: doc/BRIEF.md
# Shared Bus Multi-Master Arbiter

This block decides which of up to four processor nodes owns one shared external memory bus. The arbitration is distributed. Every node holds an identical copy of the arbiter and sees the same active-low request lines, the same priority-mode pin, the same lock line and the same time-out value. Each copy therefore reaches the same ownership decision in the same clock cycle, and no central arbiter or glue logic is needed. Each copy is told its own node number through a strap input. It raises a local grant only when that node is the owner.

The priority mode is chosen by a pin. In fixed mode the lowest-numbered requester wins. In rotating mode the search for a winner starts just after the node that most recently held the bus. The current owner can assert lock to keep the bus across several transfers. A tenure counter limits how long an unlocked owner may hold the bus while other nodes are waiting. When the limit is reached, the block emits a one-cycle time-out pulse and frees the bus. Between any two owners there is always at least one cycle with no owner, so that two nodes never drive the bus at the same time.

Top module: `shbus_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it with no request, `owner_valid_o`, `grant_o` and `timeout_o` are all 0.
- R2: With `rot_mode` = 0 (fixed priority), when the bus is free the active requester with the lowest index becomes owner. Node k requests by driving `req_n[k]` to 0.
- R3: With `rot_mode` = 1 (rotating priority), when the bus is free the winner is the first active requester found by searching upward, with wrap-around, from the index after the most recent owner. After reset, the most recent owner is taken to be node NODES-1.
- R4: An owner sampled at a clock edge is visible from that edge on. The owner keeps the bus while its own request stays low. The edge that samples its request high frees the bus. The following cycle has no owner, and a new owner can appear at the next edge. The owner never changes from one owner directly to another.
- R5: All instances report identical `owner_valid_o`, `owner_o` and `timeout_o` in every cycle. `grant_o` of an instance is 1 exactly when the bus has an owner equal to that instance's `node_id`.
- R6: While `lock` is 1 and the bus has an owner, that owner keeps the bus whatever the request lines show, the tenure counter is frozen, and no time-out occurs.
- R7: At each grant, the tenure counter loads `tmo_load`. It counts down on every unlocked cycle of ownership. Once it is zero and some other node requests, the next edge frees the bus and raises `timeout_o` for exactly one cycle. An owner that is continuously contended therefore holds the bus for `tmo_load`+1 cycles.
- R8: A node that has just timed out is left out of the arbitration that immediately follows its time-out.
- R9: A counter at zero with no other requester does not free the bus: the owner keeps it and no time-out is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | NODES | Active-low bus request, one bit per node |
| rot_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| lock | input | 1 | Current owner holds the bus |
| tmo_load | input | TMO_W | Tenure limit loaded at each grant |
| node_id | input | IDW | Index of the node this copy serves |
| grant_o | output | 1 | This node owns the bus |
| owner_valid_o | output | 1 | Some node owns the bus |
| owner_o | output | IDW | Index of the current owner |
| timeout_o | output | 1 | One-cycle pulse when a tenure is cut short |

## Verification
Every output is registered. A request sampled at an edge therefore shows on the owner and grant outputs right after that same edge. A release shows one edge later as an empty cycle, and the next owner shows one edge after that. A contended tenure of `tmo_load` = L ends with the time-out pulse in the (L+2)th cycle after the grant edge, which is also the cycle in which the owner disappears. The bench changes inputs on falling edges and samples outputs on falling edges, so each check falls exactly one rising edge after the stimulus it judges. A cycle-level model built from the requirements is compared with all four instances on every falling edge.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
    typedef enum logic {
        PRI_FIXED  = 1'b0,
        PRI_ROTATE = 1'b1
    } prio_e;
endpackage

// File: rtl/shbus_pick.sv
module shbus_pick #(
    parameter int NODES = 4,
    parameter int IDW   = $clog2(NODES)
) (
    input  logic [NODES-1:0]   act,
    input  shbus_pkg::prio_e   mode,
    input  logic [IDW-1:0]     last,
    output logic               found,
    output logic [IDW-1:0]     win
);
    logic [NODES-1:0] rot_req;
    logic [IDW-1:0]   rot_idx [NODES];
    logic [IDW-1:0]   fix_win;
    logic [IDW-1:0]   rot_win;

    // rotated view: slot i holds the node i+1 places after the last owner
    for (genvar i = 0; i < NODES; i++) begin : g_rot
        logic [IDW:0] sum;
        logic [IDW:0] wrapped;
        assign sum     = {1'b0, last} + (IDW+1)'(i + 1);
        assign wrapped = (sum >= (IDW+1)'(NODES)) ? (sum - (IDW+1)'(NODES)) : sum;
        assign rot_idx[i] = wrapped[IDW-1:0];
        assign rot_req[i] = act[wrapped[IDW-1:0]];
    end

    always_comb begin
        fix_win = '0;
        rot_win = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (act[i])     fix_win = IDW'(i);
            if (rot_req[i]) rot_win = rot_idx[i];
        end
    end

    assign found = |act;
    assign win   = (mode == shbus_pkg::PRI_ROTATE) ? rot_win : fix_win;
endmodule

// File: rtl/shbus_tenure.sv
module shbus_tenure #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             dec,
    output logic             zero_o
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = load_val;
        else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/shbus_arbiter.sv
module shbus_arbiter #(
    parameter int NODES = 4,
    parameter int TMO_W = 8,
    parameter int IDW   = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] req_n,
    input  logic             rot_mode,
    input  logic             lock,
    input  logic [TMO_W-1:0] tmo_load,
    input  logic [IDW-1:0]   node_id,
    output logic             grant_o,
    output logic             owner_valid_o,
    output logic [IDW-1:0]   owner_o,
    output logic             timeout_o
);
    typedef struct packed {
        logic           valid;
        logic [IDW-1:0] owner;
        logic [IDW-1:0] last;
        logic           tmo;
        logic           excl_v;
        logic [IDW-1:0] excl_id;
    } arb_st_t;

    arb_st_t          st_d, st_q;
    logic [NODES-1:0] cand;
    logic [NODES-1:0] owner_oh;
    logic             others;
    logic             own_req;
    logic             found;
    logic [IDW-1:0]   win;
    logic             tmr_load;
    logic             tmr_dec;
    logic             tmr_zero;

    shbus_pick #(.NODES(NODES), .IDW(IDW)) u_pick (
        .act   (cand),
        .mode  (shbus_pkg::prio_e'(rot_mode)),
        .last  (st_q.last),
        .found (found),
        .win   (win)
    );

    shbus_tenure #(.TMO_W(TMO_W)) u_tenure (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmo_load),
        .dec      (tmr_dec),
        .zero_o   (tmr_zero)
    );

    always_comb begin
        cand = ~req_n;
        if (st_q.excl_v) cand[st_q.excl_id] = 1'b0;
        owner_oh = '0;
        owner_oh[st_q.owner] = 1'b1;
        others  = |((~req_n) & ~owner_oh);
        own_req = ~req_n[st_q.owner];

        st_d     = st_q;
        st_d.tmo = 1'b0;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;

        if (!st_q.valid) begin
            st_d.excl_v = 1'b0;
            if (found) begin
                st_d.valid = 1'b1;
                st_d.owner = win;
                tmr_load   = 1'b1;
            end
        end else if (lock) begin
            st_d = st_q;
        end else if (!own_req) begin
            st_d.valid = 1'b0;
            st_d.last  = st_q.owner;
        end else if (tmr_zero) begin
            if (others) begin
                st_d.valid   = 1'b0;
                st_d.tmo     = 1'b1;
                st_d.last    = st_q.owner;
                st_d.excl_v  = 1'b1;
                st_d.excl_id = st_q.owner;
            end
        end else begin
            tmr_dec = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.last    <= IDW'(NODES - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_valid_o = st_q.valid;
    assign owner_o       = st_q.owner;
    assign timeout_o     = st_q.tmo;
    assign grant_o       = st_q.valid && (st_q.owner == node_id);
endmodule

// File: rtl/shbus_arbiter_chk.sv
module shbus_arbiter_chk #(
    parameter int NODES = 4,
    parameter int TMO_W = 8,
    parameter int IDW   = $clog2(NODES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NODES-1:0] req_n,
    input logic             lock,
    input logic             owner_valid_o,
    input logic [IDW-1:0]   owner_o,
    input logic             timeout_o
);
    logic [NODES-1:0] req_n_p;
    logic [NODES-1:0] own_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_n_p <= '1;
        else        req_n_p <= req_n;
    end

    always_comb begin
        own_bit = '0;
        own_bit[owner_o] = 1'b1;
    end

    a_r4_no_direct_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid_o && $past(owner_valid_o)) |-> (owner_o == $past(owner_o)));

    a_r4_winner_requested: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owner_valid_o) |-> !req_n_p[owner_o]);

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid_o && lock) |=> (owner_valid_o && $stable(owner_o) && !timeout_o));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    a_r7_pulse_frees_bus: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !owner_valid_o);

    a_r9_sole_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid_o && !lock && !req_n[owner_o] && ((req_n | own_bit) == '1))
        |=> (owner_valid_o && $stable(owner_o) && !timeout_o));
endmodule

bind shbus_arbiter shbus_arbiter_chk #(.NODES(NODES), .TMO_W(TMO_W), .IDW(IDW)) u_chk (.*);

// File: tb/shbus_arbiter_tb.sv
module shbus_arbiter_tb;
    localparam int N = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_n = '1;
    logic         rot_mode = 1'b0;
    logic         lock = 1'b0;
    logic [W-1:0] tmo_load = '0;

    logic       ov [N];
    logic [1:0] ow [N];
    logic       gt [N];
    logic       to [N];

    int n_vec = 0, n_bad = 0, m_vec = 0, m_bad = 0;
    bit done = 0;
    bit mon_on = 0;

    always #5 clk = ~clk;

    shbus_arbiter #(.NODES(N), .TMO_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .rot_mode(rot_mode), .lock(lock),
        .tmo_load(tmo_load), .node_id(2'd0), .grant_o(gt[0]), .owner_valid_o(ov[0]),
        .owner_o(ow[0]), .timeout_o(to[0]));

    for (genvar k = 1; k < N; k++) begin : g_node
        shbus_arbiter #(.NODES(N), .TMO_W(W)) u_node (
            .clk(clk), .rst_n(rst_n), .req_n(req_n), .rot_mode(rot_mode), .lock(lock),
            .tmo_load(tmo_load), .node_id(2'(k)), .grant_o(gt[k]), .owner_valid_o(ov[k]),
            .owner_o(ow[k]), .timeout_o(to[k]));
    end

    // cycle model written from the requirements
    logic       mv, mt, mxv;
    logic [1:0] mo, ml, mx;
    int         mc;

    function automatic int pick(input logic [N-1:0] act, input logic rot, input int last);
        for (int off = 0; off < N; off++) begin
            int idx;
            idx = rot ? (last + 1 + off) % N : off;
            if (act[idx]) return idx;
        end
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mv <= 0; mt <= 0; mxv <= 0; mo <= 0; ml <= 2'(N - 1); mx <= 0; mc <= 0;
        end else begin
            logic [N-1:0] act;
            int w;
            act = ~req_n;
            mt <= 0;
            if (!mv) begin
                if (mxv) act[mx] = 1'b0;
                mxv <= 0;
                w = pick(act, rot_mode, int'(ml));
                if (w >= 0) begin mv <= 1; mo <= 2'(w); mc <= int'(tmo_load); end
            end else if (lock) begin
            end else if (req_n[mo]) begin
                mv <= 0; ml <= mo;
            end else if (mc == 0) begin
                act[mo] = 1'b0;
                if (act != 0) begin mv <= 0; mt <= 1; ml <= mo; mxv <= 1; mx <= mo; end
            end else begin
                mc <= mc - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_vec++;
                if (ov[i] !== mv || to[i] !== mt || (mv && ow[i] !== mo)) begin
                    m_bad++;
                    $display("FAIL R5 node %0d: valid/owner/tmo %b/%0d/%b expected %b/%0d/%b",
                             i, ov[i], ow[i], to[i], mv, mo, mt);
                end
                m_vec++;
                if (gt[i] !== (mv && mo == 2'(i))) begin
                    m_bad++;
                    $display("FAIL R5 node %0d grant: %b expected %b", i, gt[i], (mv && mo == 2'(i)));
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_all();
        req_n = '1; lock = 0; tick(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec + m_vec, n_bad + m_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        int prev, held;
        // R1 reset state
        tick(1);
        for (int i = 0; i < N; i++)
            chk(!ov[i] && !gt[i] && !to[i], "R1 in reset", {ov[i], gt[i], to[i]}, 0);
        rst_n = 1; mon_on = 1;
        tick(1);
        for (int i = 0; i < N; i++)
            chk(!ov[i] && !gt[i] && !to[i], "R1 after reset", {ov[i], gt[i], to[i]}, 0);

        // R2 fixed priority over every request pattern
        rot_mode = 0; tmo_load = 8'hFF;
        for (int p = 1; p < 16; p++) begin
            int exp;
            exp = pick(4'(p), 1'b0, 0);
            req_n = ~4'(p);
            tick(1);
            chk(ov[0] && ow[0] == 2'(exp), "R2 lowest wins", int'(ow[0]), exp);
            for (int i = 0; i < N; i++)
                chk(gt[i] == (i == exp), "R5 local grant", int'(gt[i]), int'(i == exp));
            idle_all();
        end

        // R4 release gives one empty cycle, then the next owner
        req_n = 4'b0011;
        tick(1);
        chk(ov[0] && ow[0] == 2'd2, "R4 first owner", int'(ow[0]), 2);
        req_n = 4'b0111;
        tick(1);
        chk(!ov[0], "R4 gap cycle", int'(ov[0]), 0);
        tick(1);
        chk(ov[0] && ow[0] == 2'd3, "R4 next owner", int'(ow[0]), 3);
        idle_all();

        // R3 rotation with all nodes requesting
        rot_mode = 1; prev = 3;
        req_n = '0;
        tick(1);
        for (int k = 0; k < 8; k++) begin
            int exp;
            exp = (prev + 1) % N;
            chk(ov[0] && ow[0] == 2'(exp), "R3 rotate", int'(ow[0]), exp);
            req_n = '0; req_n[exp] = 1'b1;
            tick(1);
            chk(!ov[0], "R4 rotate gap", int'(ov[0]), 0);
            req_n = '0;
            tick(1);
            prev = exp;
        end
        idle_all();

        // R6 lock keeps owner without its request, counter frozen at zero
        rot_mode = 0; tmo_load = 0;
        req_n = 4'b1101;
        tick(1);
        chk(ow[0] == 2'd1 && ov[0], "R6 owner", int'(ow[0]), 1);
        lock = 1; req_n = 4'b0010;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            chk(ov[0] && ow[0] == 2'd1 && !to[0], "R6 locked", int'(ow[0]), 1);
        end
        lock = 0;
        tick(1);
        chk(!ov[0] && !to[0], "R6 release after unlock", {ov[0], to[0]}, 0);
        idle_all();

        // R7 tenure length and R8 exclusion
        for (int L = 0; L < 9; L += 3) begin
            tmo_load = 8'(L);
            req_n = 4'b1110;
            tick(1);
            held = 0;
            req_n = 4'b1100;
            while (ov[0] && ow[0] == 2'd0 && held < 20) begin
                held++;
                tick(1);
            end
            chk(held == L + 1, "R7 tenure cycles", held, L + 1);
            chk(to[0] && !ov[0], "R7 pulse", int'(to[0]), 1);
            tick(1);
            chk(!to[0], "R7 pulse one cycle", int'(to[0]), 0);
            chk(ov[0] && ow[0] == 2'd1, "R8 timed-out node skipped", int'(ow[0]), 1);
            idle_all();
        end

        // R9 lone owner at zero count keeps the bus
        tmo_load = 0;
        req_n = 4'b0111;
        tick(1);
        for (int k = 0; k < 20; k++) begin
            tick(1);
            chk(ov[0] && ow[0] == 2'd3 && !to[0], "R9 sole owner kept", int'(ow[0]), 3);
        end
        idle_all();

        // mixed traffic, checked against the model every cycle
        lfsr = 16'hACE1;
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rot_mode = (c / 500) % 2 == 1;
            req_n = lfsr[3:0] | lfsr[7:4];
            lock = &lfsr[10:8];
            tmo_load = {5'd0, lfsr[13:11]};
            tick(1);
        end
        idle_all();
        finish_run();
    end
endmodule